// File: doc/BRIEF.md
# Parallel Handshake Strobe and Edge Flags

This block drives the handshake side of a byte-wide parallel port. Each read or write that targets the handshake data port starts a fixed sequence. The active-low strobe stays high for a set number of clock cycles and then drives low for a set number of cycles. A receiving device can treat the strobe as "data ready" or "data accepted". A wider transfer is made by accessing the other byte port first and the handshake port last. Only that last access produces the strobe.

Two active-low flag pins are asynchronous to the clock. Each pin passes through a synchroniser and a falling-edge detector. A falling edge sets a sticky status bit, which software clears by writing one to it. Each status bit has an enable bit. The interrupt request is asserted while any enabled status bit is set.

Top module: `pio_handshake`

## Requirements
- R1: While reset is high and on the first cycle after it, `strobe_n_o` is 1, `flag_o` is all zero, `irq_o` is 0 and all enables are cleared.
- R2: An access is sampled at edge k when `acc_valid_i` is 1 and `acc_port_i` equals `HS_PORT` (3 by default). For that access, `strobe_n_o` stays 1 after edges k and k+1. It is 0 after edge k+`DELAY_CYC` (k+2 by default).
- R3: Once low, `strobe_n_o` stays 0 for exactly `LOW_CYC` cycles (2 by default). It then returns to 1 and stays there until the next access.
- R4: An access with `acc_port_i` different from `HS_PORT` never changes `strobe_n_o`.
- R5: An access to the handshake port during the delay or the low phase restarts the sequence. `strobe_n_o` is 1 after that edge, and the timing of R2 and R3 is counted from the new access.
- R6: A falling edge on `flag_n_i[i]` sets `flag_o[i]`. Bit 0 is flag A and bit 1 is flag B. If the pin is first sampled low at edge e, the bit is 1 after edge e+2. Rising edges and a pin held low set nothing.
- R7: A set flag bit stays set until a cycle with `clr_we_i` = 1 and `clr_data_i[i]` = 1 clears it. A zero in `clr_data_i[i]` leaves bit i unchanged.
- R8: When a clear of bit i and a detected falling edge of flag i fall in the same cycle, bit i is 1 afterwards.
- R9: `en_we_i` = 1 loads `en_data_i` into the enable bits. `irq_o` equals the OR over i of (flag bit i AND enable bit i). It updates on the same edge as the flag and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | One-cycle pulse for a read or write of a port |
| acc_port_i | input | PORT_W | Port addressed by the access |
| flag_n_i | input | NUM_FLAGS | Asynchronous active-low flag pins |
| clr_we_i | input | 1 | Write strobe for the write-one-to-clear of the flag bits |
| clr_data_i | input | NUM_FLAGS | Flag bits to clear |
| en_we_i | input | 1 | Write strobe for the enable bits |
| en_data_i | input | NUM_FLAGS | New enable bits |
| strobe_n_o | output | 1 | Active-low handshake strobe |
| flag_o | output | NUM_FLAGS | Sticky flag status bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-cycle delay, a two-cycle low width, two flags, two synchroniser stages and a two-bit port select. With these values, each restart point can be reached within a few cycles. A restart can land in the first or second delay cycle or in either low cycle, and back-to-back accesses are also reachable. The bench also lines up a clear with a flag edge whose timing through the synchroniser is known exactly. Flags A and B are driven both separately and at the same time, so the enable mask is checked with each bit alone and with both bits together.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_WAIT  = 2'd1,
    HS_PULSE = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_strobe_gen.sv
module hs_strobe_gen #(
  parameter int DELAY_CYC = 2,
  parameter int LOW_CYC   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic strobe_n_o
);
  import hs_pkg::*;

  localparam int MAXC = (DELAY_CYC > LOW_CYC) ? DELAY_CYC : LOW_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(LOW_CYC - 1);

  hs_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= HS_IDLE;
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else if (trig_i) begin
      state_q  <= HS_WAIT;
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else begin
      case (state_q)
        HS_WAIT: begin
          if (cnt_q == DLY_LAST) begin
            state_q  <= HS_PULSE;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HS_PULSE: begin
          if (cnt_q == LOW_LAST) begin
            state_q  <= HS_IDLE;
            cnt_q    <= '0;
            strobe_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q  <= HS_IDLE;
          cnt_q    <= '0;
          strobe_q <= 1'b1;
        end
      endcase
    end
  end

  assign strobe_n_o = strobe_q;
endmodule

// File: rtl/hs_flag_sync.sv
module hs_flag_sync #(
  parameter int NUM_FLAGS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] pin_n_i,
  output logic [NUM_FLAGS-1:0] fall_o
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        prev_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i[i]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign fall_o[i] = prev_q & ~sync_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/hs_flag_regs.sv
module hs_flag_regs #(
  parameter int NUM_FLAGS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] fall_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_data_i,
  input  logic                 en_we_i,
  input  logic [NUM_FLAGS-1:0] en_data_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic [NUM_FLAGS-1:0] en_o,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] flag_q, flag_d, en_q, en_d, clr_mask;
  logic                 irq_q;

  always_comb begin
    clr_mask = clr_we_i ? clr_data_i : '0;
    flag_d   = (flag_q & ~clr_mask) | fall_i;
    en_d     = en_we_i ? en_data_i : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= |(flag_d & en_d);
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/pio_handshake.sv
module pio_handshake #(
  parameter int PORT_W      = 2,
  parameter int HS_PORT     = 3,
  parameter int DELAY_CYC   = 2,
  parameter int LOW_CYC     = 2,
  parameter int NUM_FLAGS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid_i,
  input  logic [PORT_W-1:0]    acc_port_i,
  input  logic [NUM_FLAGS-1:0] flag_n_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_data_i,
  input  logic                 en_we_i,
  input  logic [NUM_FLAGS-1:0] en_data_i,
  output logic                 strobe_n_o,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic                 irq_o
);
  localparam logic [PORT_W-1:0] HS_SEL = PORT_W'(HS_PORT);

  logic                 hs_hit;
  logic [NUM_FLAGS-1:0] fall;
  logic [NUM_FLAGS-1:0] en_q;

  assign hs_hit = acc_valid_i && (acc_port_i == HS_SEL);

  hs_strobe_gen #(.DELAY_CYC(DELAY_CYC), .LOW_CYC(LOW_CYC)) u_strobe (
    .clk(clk), .rst(rst), .trig_i(hs_hit), .strobe_n_o(strobe_n_o)
  );

  hs_flag_sync #(.NUM_FLAGS(NUM_FLAGS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n_i(flag_n_i), .fall_o(fall)
  );

  hs_flag_regs #(.NUM_FLAGS(NUM_FLAGS)) u_regs (
    .clk(clk), .rst(rst), .fall_i(fall),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .en_we_i(en_we_i), .en_data_i(en_data_i),
    .flag_o(flag_o), .en_o(en_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/pio_handshake_chk.sv
module pio_handshake_chk #(
  parameter int NUM_FLAGS = 2,
  parameter int LOW_CYC   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 hs_acc,
  input logic                 strobe_n,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] en,
  input logic                 clr_we,
  input logic [NUM_FLAGS-1:0] clr_data,
  input logic                 irq
);
  // R1: outputs idle on the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (strobe_n && flags == '0 && !irq && en == '0));

  // R2 / R5: an access leaves the strobe high on the next cycle
  p_access_high_r2: assert property (@(posedge clk) disable iff (rst)
    hs_acc |=> strobe_n);

  if (LOW_CYC >= 2) begin : g_width
    // R3: a low pulse lasts beyond its first cycle unless restarted
    p_low_width_r3: assert property (@(posedge clk) disable iff (rst)
      ($fell(strobe_n) && !hs_acc) |=> !strobe_n);
  end

  // R9: interrupt tracks enabled status bits
  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & en));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_hold
    // R7: a set bit survives any cycle that does not clear it
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(clr_we && clr_data[i])) |=> flags[i]);
  end
endmodule

bind pio_handshake pio_handshake_chk #(.NUM_FLAGS(NUM_FLAGS), .LOW_CYC(LOW_CYC)) u_chk (
  .clk(clk), .rst(rst), .hs_acc(hs_hit), .strobe_n(strobe_n_o),
  .flags(flag_o), .en(en_q), .clr_we(clr_we_i), .clr_data(clr_data_i),
  .irq(irq_o)
);

// File: tb/pio_handshake_bench.sv
module pio_handshake_bench;
  localparam int PW = 2;
  localparam int HSP = 3;
  localparam int DLY = 2;
  localparam int LOW = 2;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [PW-1:0] acc_port = '0;
  logic [NF-1:0] flag_n = '1;
  logic clr_we = 1'b0;
  logic [NF-1:0] clr_data = '0;
  logic en_we = 1'b0;
  logic [NF-1:0] en_data = '0;
  logic strobe_n;
  logic [NF-1:0] flags;
  logic irq;

  always #5 clk = ~clk;

  pio_handshake u_pio_handshake (
    .clk(clk), .rst(rst), .acc_valid_i(acc_valid), .acc_port_i(acc_port),
    .flag_n_i(flag_n), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .en_we_i(en_we), .en_data_i(en_data),
    .strobe_n_o(strobe_n), .flag_o(flags), .irq_o(irq)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit live = 0;

  // behavioural reference
  int since = -1;
  logic [NF-1:0] m_flags = '0, m_en = '0;
  logic m_irq = 1'b0;
  logic [NF-1:0] pin_hist[$];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      since = -1; m_flags = '0; m_en = '0; m_irq = 1'b0;
      pin_hist = '{'1, '1, '1, '1};
    end else begin
      logic [NF-1:0] fall;
      pin_hist.push_front(flag_n);
      void'(pin_hist.pop_back());
      fall = ~pin_hist[2] & pin_hist[3];
      m_flags = (m_flags & ~(clr_we ? clr_data : '0)) | fall;
      if (en_we) m_en = en_data;
      m_irq = |(m_flags & m_en);
      if (acc_valid && acc_port == PW'(HSP)) since = 0;
      else if (since >= 0 && since < DLY + LOW) since++;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check("R2/R3/R4/R5 strobe", int'(strobe_n),
            (since >= DLY && since < DLY + LOW) ? 0 : 1);
      check("R6/R7/R8 flags", int'(flags), int'(m_flags));
      check("R9 irq", int'(irq), int'(m_irq));
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    finish_run();
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(logic [PW-1:0] p);
    @(negedge clk); acc_valid = 1'b1; acc_port = p;
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic clear(logic [NF-1:0] d);
    @(negedge clk); clr_we = 1'b1; clr_data = d;
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic enable(logic [NF-1:0] d);
    @(negedge clk); en_we = 1'b1; en_data = d;
    @(negedge clk); en_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 strobe in reset", int'(strobe_n), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 strobe after reset", int'(strobe_n), 1);
    check("R1 flags after reset", int'(flags), 0);
    check("R1 irq after reset", int'(irq), 0);
    live = 1;

    // R2, R3 single access: explicit phase checks
    @(negedge clk); acc_valid = 1'b1; acc_port = PW'(HSP);
    @(negedge clk); acc_valid = 1'b0;
    check("R2 high after k", int'(strobe_n), 1);
    @(negedge clk); check("R2 high after k+1", int'(strobe_n), 1);
    @(negedge clk); check("R2 low after k+2", int'(strobe_n), 0);
    @(negedge clk); check("R3 low after k+3", int'(strobe_n), 0);
    @(negedge clk); check("R3 high after k+4", int'(strobe_n), 1);
    idle(3);

    // R4 other ports
    for (int p = 0; p < HSP; p++) begin
      access(PW'(p)); idle(5);
    end

    // R5 restarts at every phase, then back to back
    for (int gap = 0; gap < DLY + LOW; gap++) begin
      access(PW'(HSP)); idle(gap); access(PW'(HSP)); idle(6);
    end
    @(negedge clk); acc_valid = 1'b1; acc_port = PW'(HSP);
    idle(3);
    acc_valid = 1'b0;
    idle(6);

    // R6 flag A, then flag B, rise and held low
    flag_n = 2'b10; idle(5);
    check("R6 flag A set", int'(flags), 1);
    flag_n = 2'b11; idle(5);
    flag_n = 2'b01; idle(8);
    check("R6 flag B set", int'(flags), 3);
    // R7 clear with zero data, then A only
    clear(2'b00); idle(2);
    check("R7 zero clear keeps", int'(flags), 3);
    clear(2'b01); idle(2);
    check("R7 clear A", int'(flags), 2);
    flag_n = 2'b11; idle(4);
    check("R6 rise sets nothing", int'(flags), 2);

    // R9 enables
    enable(2'b01); idle(1); check("R9 masked", int'(irq), 0);
    enable(2'b10); idle(1); check("R9 B enabled", int'(irq), 1);
    enable(2'b11); clear(2'b11); idle(1);
    check("R9 cleared", int'(irq), 0);

    // R8 clear coincides with detected edge of A (set beforehand)
    flag_n = 2'b10; idle(5); flag_n = 2'b11; idle(4);
    @(negedge clk); flag_n = 2'b10;
    @(negedge clk);
    @(negedge clk); clr_we = 1'b1; clr_data = 2'b01;
    @(negedge clk); clr_we = 1'b0; clr_data = '0;
    check("R8 set wins", int'(flags[0]), 1);
    idle(2);
    // both flags together with an access in flight
    flag_n = 2'b11; idle(3);
    clear(2'b11);
    access(PW'(HSP)); flag_n = 2'b00; idle(8);
    check("R6 both flags", int'(flags), 3);
    idle(4);
    finish_run();
  end
endmodule